// File: doc/BRIEF.md
# Per-Group Cell Rate Pacing Timer Table

This block paces cell processing for up to eight inverse-multiplexed groups. All groups share one master tick input. Each group has a countdown entry with a period that software programs, and the period has an integer part and a fractional part. When an enabled entry runs out on a tick, the block asks for exactly one cell from that group's delay-compensation buffer. It then reloads the entry from the programmed period. A fractional accumulator carries the remainder from one reload to the next, so a non-integer rate shows up as a mix of interval lengths and does not drift.

Requests leave the block one per clock cycle. When several entries run out on the same tick, they are served in ascending group order, and a pending bit per group holds each one until it is served. In the cycle a request is served, the block samples a per-group cell-available input. Three served requests in a row that find no cell set that group's sticky service-timeout flag. Software clears the flag by writing 1 to it.

Master ticks are expected to arrive at least NG+1 clock cycles apart, so every pending request is served before the next tick.

Top module: `cell_pace_table`

## Requirements
- R1: After reset, all entries are disabled, `req_valid_o` is 0 and every bit of `timeout_o` is 0.
- R2: A configuration write with `cfg_en_i`=1 to a disabled entry loads the entry with the integer part of the period. The first request for that group follows on the P-th master tick after the write, where P is bits [23:8] of `cfg_period_i`.
- R3: Each time an enabled entry runs out, the block issues exactly one request for that group. The entry then reloads, so an integer period P gives one request every P ticks.
- R4: Bits [7:0] of `cfg_period_i` are a fraction in units of 1/256. The fraction is added into a per-group accumulator at each reload, and a carry out of that accumulator lengthens the next interval by one tick. For example, period 2 + 128/256 gives requests on relative ticks 2, 4, 7 and 9.
- R5: A disabled entry does not count and issues no requests. Disabling an entry drops any request it has pending. Re-enabling the entry restarts it with a full period, as in R2.
- R6: Writing a new period to an entry that is already enabled does not change its current countdown. The new period applies from the next reload.
- R7: When entries run out on the same tick, their requests appear on consecutive clock cycles in ascending group order. `req_grp_o` gives the group number, and each request is held valid for exactly one cycle.
- R8: When three requests for a group in a row are served while `cell_avail_i` for that group is 0, `timeout_o` for that group goes to 1 on the clock edge that serves the third request.
- R9: A request that is served while `cell_avail_i` for its group is 1 resets that group's count of requests that found no cell.
- R10: Writing 1 to a bit of `to_clr_i` clears that bit of `timeout_o`. If the flag is set and cleared on the same edge, the set wins and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Shared master tick, one cycle wide |
| cfg_we_i | input | 1 | Entry write strobe |
| cfg_grp_i | input | GW | Group number for the entry write |
| cfg_period_i | input | IW+FW | Period: integer part in the upper IW bits, fraction in the lower FW bits |
| cfg_en_i | input | 1 | Enable value for the entry write |
| to_clr_i | input | NG | Write-1-to-clear strobes for the timeout flags |
| cell_avail_i | input | NG | A data cell is waiting, per group |
| req_valid_o | output | 1 | Request to process one cell |
| req_grp_o | output | GW | Group number of the request |
| timeout_o | output | NG | Sticky service-timeout flags |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is the third empty request, which sets a timeout flag, and a software clear of that same flag. The bench provokes this by raising `to_clr_i` in the very cycle that `req_valid_o` shows the third empty request. It then checks that the flag reads 1 afterwards and clears on a later, separate write. The second pair is several entries running out on one tick. The bench enables three groups out of order with equal periods and checks that their requests come out on consecutive cycles in ascending group order.

// File: rtl/cell_pace_table.sv
module cell_pace_table #(
  parameter int NG = 8,
  parameter int IW = 16,
  parameter int FW = 8,
  localparam int GW = $clog2(NG),
  localparam int PW = IW + FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cfg_we_i,
  input  logic [GW-1:0] cfg_grp_i,
  input  logic [PW-1:0] cfg_period_i,
  input  logic          cfg_en_i,
  input  logic [NG-1:0] to_clr_i,
  input  logic [NG-1:0] cell_avail_i,
  output logic          req_valid_o,
  output logic [GW-1:0] req_grp_o,
  output logic [NG-1:0] timeout_o
);

  logic [NG-1:0] pend_v;

  assign req_valid_o = |pend_v;

  always_comb begin
    req_grp_o = '0;
    for (int i = NG - 1; i >= 0; i--)
      if (pend_v[i]) req_grp_o = GW'(i);
  end

  for (genvar g = 0; g < NG; g++) begin : g_ent
    logic          en_q, pend_q, to_q;
    logic [IW-1:0] per_int_q, cnt_q;
    logic [FW-1:0] per_frac_q, acc_q;
    logic [1:0]    miss_q;
    logic [FW:0]   acc_sum;
    logic          wr, dis, arm, take, expire, to_set;

    assign wr      = cfg_we_i && (cfg_grp_i == GW'(g));
    assign dis     = wr && !cfg_en_i;
    assign arm     = wr && cfg_en_i && !en_q;
    assign take    = req_valid_o && (req_grp_o == GW'(g));
    assign expire  = tick_i && en_q && !dis && (cnt_q <= IW'(1));
    assign acc_sum = {1'b0, acc_q} + {1'b0, per_frac_q};
    assign to_set  = take && !dis && !cell_avail_i[g] && (miss_q == 2'd2);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q       <= 1'b0;
        per_int_q  <= '0;
        per_frac_q <= '0;
        cnt_q      <= '0;
        acc_q      <= '0;
      end else begin
        if (wr) begin
          en_q       <= cfg_en_i;
          per_int_q  <= cfg_period_i[PW-1:FW];
          per_frac_q <= cfg_period_i[FW-1:0];
        end
        if (arm) begin
          cnt_q <= cfg_period_i[PW-1:FW];
          acc_q <= '0;
        end else if (tick_i && en_q && !dis) begin
          if (expire) begin
            cnt_q <= per_int_q + IW'(acc_sum[FW]);
            acc_q <= acc_sum[FW-1:0];
          end else begin
            cnt_q <= cnt_q - IW'(1);
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        miss_q <= '0;
        to_q   <= 1'b0;
      end else begin
        if (dis)         pend_q <= 1'b0;
        else if (expire) pend_q <= 1'b1;
        else if (take)   pend_q <= 1'b0;

        if (dis)                  miss_q <= '0;
        else if (take) begin
          if (cell_avail_i[g])    miss_q <= '0;
          else if (to_set)        miss_q <= '0;
          else                    miss_q <= miss_q + 2'd1;
        end

        if (to_set)           to_q <= 1'b1;
        else if (to_clr_i[g]) to_q <= 1'b0;
      end
    end

    assign pend_v[g]    = pend_q;
    assign timeout_o[g] = to_q;
  end

endmodule

// File: rtl/cell_pace_table_chk.sv
module cell_pace_table_chk #(
  parameter int NG = 8,
  parameter int GW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          cfg_we_i,
  input logic [GW-1:0] cfg_grp_i,
  input logic          cfg_en_i,
  input logic [NG-1:0] to_clr_i,
  input logic          req_valid_o,
  input logic [GW-1:0] req_grp_o,
  input logic [NG-1:0] timeout_o
);

  logic [NG-1:0] req_vec;
  assign req_vec = req_valid_o ? (NG'(1) << req_grp_o) : '0;

  // R7
  one_shot_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !tick_i) |=> !(req_valid_o && req_grp_o == $past(req_grp_o)));

  // R3
  req_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !req_valid_o) |=> !req_valid_o);

  // R5
  disable_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !cfg_en_i) |=> !(req_valid_o && req_grp_o == $past(cfg_grp_i)));

  // R8
  timeout_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((timeout_o & ~$past(timeout_o) & ~$past(req_vec)) == '0));

  // R10
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(timeout_o) & ~$past(to_clr_i) & ~timeout_o) == '0));

endmodule

bind cell_pace_table cell_pace_table_chk #(.NG(NG), .GW(GW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_grp_i   (cfg_grp_i),
  .cfg_en_i    (cfg_en_i),
  .to_clr_i    (to_clr_i),
  .req_valid_o (req_valid_o),
  .req_grp_o   (req_grp_o),
  .timeout_o   (timeout_o)
);

// File: tb/cell_pace_table_tb.sv
module cell_pace_table_tb;
  localparam int CLK_P = 10;
  localparam int NG = 8;
  localparam int GW = 3;
  localparam int PW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [GW-1:0] cfg_grp_i = '0;
  logic [PW-1:0] cfg_period_i = '0;
  logic          cfg_en_i = 1'b0;
  logic [NG-1:0] to_clr_i = '0;
  logic [NG-1:0] cell_avail_i = '1;
  logic          req_valid_o;
  logic [GW-1:0] req_grp_o;
  logic [NG-1:0] timeout_o;

  cell_pace_table u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_we_i(cfg_we_i),
    .cfg_grp_i(cfg_grp_i), .cfg_period_i(cfg_period_i), .cfg_en_i(cfg_en_i),
    .to_clr_i(to_clr_i), .cell_avail_i(cell_avail_i),
    .req_valid_o(req_valid_o), .req_grp_o(req_grp_o), .timeout_o(timeout_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, tick_no = 0, nlog = 0;
  int log_grp [64];
  int log_tick [64];
  int log_cyc [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && req_valid_o && nlog < 64) begin
      log_grp[nlog]  = int'(req_grp_o);
      log_tick[nlog] = tick_no;
      log_cyc[nlog]  = cyc;
      nlog++;
    end

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cfg(int g, int per, bit en);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_grp_i = GW'(g); cfg_period_i = PW'(per); cfg_en_i = en;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_i = 1'b1; tick_no++;
    @(negedge clk);
    tick_i = 1'b0;
    repeat (NG + 2) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 req_valid", int'(req_valid_o), 0);
    chk("R1 timeout", int'(timeout_o), 0);
  endtask

  task automatic t_period();
    int t0;
    cfg(1, 4 << 8, 1'b1);
    t0 = tick_no; nlog = 0;
    ticks(13);
    chk("R3 count", nlog, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R2 R3 tick", log_tick[k] - t0, 4 * (k + 1));
      chk("R3 grp", log_grp[k], 1);
    end
    cfg(1, 4 << 8, 1'b0);
  endtask

  task automatic t_frac();
    int t0;
    int exp_t [4] = '{2, 4, 7, 9};
    cfg(0, (2 << 8) | 8'h80, 1'b1);
    t0 = tick_no; nlog = 0;
    ticks(10);
    chk("R4 count", nlog, 4);
    for (int k = 0; k < 4; k++) chk("R4 tick", log_tick[k] - t0, exp_t[k]);
    cfg(0, 0, 1'b0);
  endtask

  task automatic t_disable();
    int t0;
    cfg(2, 3 << 8, 1'b1);
    ticks(2);
    cfg(2, 3 << 8, 1'b0);
    nlog = 0;
    ticks(5);
    chk("R5 no req while off", nlog, 0);
    cfg(2, 3 << 8, 1'b1);
    t0 = tick_no; nlog = 0;
    ticks(3);
    chk("R5 restart count", nlog, 1);
    chk("R5 restart tick", log_tick[0] - t0, 3);
    cfg(2, 0, 1'b0);
  endtask

  task automatic t_rewrite();
    int t0;
    int exp_t [3] = '{3, 8, 13};
    cfg(4, 3 << 8, 1'b1);
    t0 = tick_no; nlog = 0;
    ticks(1);
    cfg(4, 5 << 8, 1'b1);
    ticks(12);
    chk("R6 count", nlog, 3);
    for (int k = 0; k < 3; k++) chk("R6 tick", log_tick[k] - t0, exp_t[k]);
    cfg(4, 0, 1'b0);
  endtask

  task automatic t_order();
    int exp_g [3] = '{1, 3, 6};
    cfg(6, 2 << 8, 1'b1);
    cfg(1, 2 << 8, 1'b1);
    cfg(3, 2 << 8, 1'b1);
    nlog = 0;
    ticks(2);
    chk("R7 count", nlog, 3);
    for (int k = 0; k < 3; k++) chk("R7 order", log_grp[k], exp_g[k]);
    chk("R7 back to back 1", log_cyc[1] - log_cyc[0], 1);
    chk("R7 back to back 2", log_cyc[2] - log_cyc[1], 1);
    cfg(6, 0, 1'b0); cfg(1, 0, 1'b0); cfg(3, 0, 1'b0);
  endtask

  task automatic t_timeout();
    cell_avail_i[5] = 1'b0;
    cfg(5, 1 << 8, 1'b1);
    ticks(2);
    chk("R8 not after two", int'(timeout_o[5]), 0);
    ticks(1);
    chk("R8 set after three", int'(timeout_o[5]), 1);
    chk("R8 other groups clear", int'(timeout_o & 8'hDF), 0);
    @(negedge clk); to_clr_i = 8'h20;
    @(negedge clk); to_clr_i = '0;
    chk("R10 clear", int'(timeout_o[5]), 0);
    ticks(2);
    cell_avail_i[5] = 1'b1;
    ticks(1);
    cell_avail_i[5] = 1'b0;
    ticks(2);
    chk("R9 run broken", int'(timeout_o[5]), 0);
    ticks(1);
    chk("R9 new run of three", int'(timeout_o[5]), 1);
    @(negedge clk); to_clr_i = 8'h20;
    @(negedge clk); to_clr_i = '0;
    chk("R10 clear again", int'(timeout_o[5]), 0);
    ticks(2);
    @(negedge clk);
    tick_i = 1'b1; tick_no++;
    @(negedge clk);
    tick_i = 1'b0;
    chk("R10 third request visible", int'(req_valid_o), 1);
    to_clr_i = 8'h20;
    @(negedge clk);
    to_clr_i = '0;
    chk("R10 set wins", int'(timeout_o[5]), 1);
    repeat (NG) @(negedge clk);
    to_clr_i = 8'h20;
    @(negedge clk);
    to_clr_i = '0;
    chk("R10 later clear", int'(timeout_o[5]), 0);
    cfg(5, 0, 1'b0);
    cell_avail_i[5] = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period();
    t_frac();
    t_disable();
    t_rewrite();
    t_order();
    t_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule